// File: doc/BRIEF.md
# Link Integrity Monitor

This block decides whether a 10/100 Ethernet PHY has a usable 100 Mb/s link. Receive signal processing supplies a signal-valid qualifier. Once that qualifier rises, the monitor waits out a settling interval counted in millisecond ticks. It then either waits for a go-ahead from the auto-negotiation engine or, when auto-negotiation is off, declares the link up straight away.

While the link is up, the monitor enables the transmit and receive logic. If the qualifier is lost, the link and the enable drop in the same cycle, and the machine falls back to its idle state.

The reported link status feeds a status bit and a LED. In 10 Mb/s operation it is taken from the 10BASE-T receiver's own link indication. The monitor's state code is brought out for debug.

Top module: `link_monitor`

## Requirements
- R1: While reset is high, and on the first cycle after it, the state code is 0 (Down), and both `link_status` (with `mode_10bt` low) and `txrx_enable` are 0.
- R2: State codes are 0 = Down, 1 = Settling, 2 = Ready, 3 = Up. From Down with `data_valid` high, the machine enters Settling at the next clock edge.
- R3: The machine leaves Settling only after SETTLE_TICKS ticks of `ms_tick` have been counted in Settling with `data_valid` high. It moves on at the clock edge that samples the last of those ticks; a tick seen in Down is not counted.
- R4: If `data_valid` falls during Settling, the tick count restarts from zero. A later rise then needs the full SETTLE_TICKS ticks again.
- R5: With `an_enable` high, Settling ends in Ready. Ready holds while `an_link_ok` is low, and moves to Up at the edge that samples `an_link_ok` high.
- R6: With `an_enable` low, Settling ends directly in Up. Clearing `an_enable` while in Ready moves the machine to Up at the next edge.
- R7: When `data_valid` is low, the 100 Mb/s link indication and `txrx_enable` are 0 in that same cycle. The state is Down after the next edge, whatever the previous state.
- R8: `txrx_enable` is 1 only in Up with `data_valid` high.
- R9: `link_status` equals `link_10bt` when `mode_10bt` is 1. Otherwise it is 1 only in Up with `data_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_valid | input | 1 | Signal-valid qualifier from receive processing |
| an_enable | input | 1 | Auto-negotiation is enabled |
| an_link_ok | input | 1 | Go-ahead from auto-negotiation |
| mode_10bt | input | 1 | 10BASE-T operation selected |
| link_10bt | input | 1 | Link indication from the 10BASE-T receiver |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| link_status | output | 1 | Reported link status |
| txrx_enable | output | 1 | Enable for transmit and receive logic |
| fsm_state | output | 2 | Current state code (debug) |

## Verification
A wrong tick count shows at `fsm_state` as an early or late step out of Settling, visible in the cycle after the last expected tick. A count that is not cleared shows as a short settling interval after a dropout. A stuck state or a missed auto-negotiation gate shows as a wrong code, or a wrong `link_status`, one edge after the triggering input. A slow dropout path shows as `link_status` or `txrx_enable` still high in the very cycle `data_valid` falls.

// File: rtl/link_monitor_pkg.sv
package link_monitor_pkg;

    typedef enum logic [1:0] {
        LNK_DOWN   = 2'd0,
        LNK_SETTLE = 2'd1,
        LNK_READY  = 2'd2,
        LNK_UP     = 2'd3
    } lnk_state_e;

    typedef struct packed {
        logic dv;
        logic an_en;
        logic an_ok;
    } lnk_ctl_t;

    function automatic lnk_state_e lnk_next(lnk_state_e cur, lnk_ctl_t c, logic settled);
        lnk_state_e nxt;
        nxt = cur;
        if (!c.dv) begin
            nxt = LNK_DOWN;
        end else begin
            case (cur)
                LNK_DOWN:   nxt = LNK_SETTLE;
                LNK_SETTLE: if (settled) nxt = c.an_en ? LNK_READY : LNK_UP;
                LNK_READY:  if (!c.an_en || c.an_ok) nxt = LNK_UP;
                default:    nxt = LNK_UP;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_TICKS = 330
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(SETTLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(SETTLE_TICKS));
    a_r4_count_restart: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
    a_r3_idle_tick: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> cnt == $past(cnt));
endmodule

// File: rtl/link_fsm.sv
module link_fsm
    import link_monitor_pkg::*;
#(
    parameter int SETTLE_TICKS = 330
) (
    input  logic       clk,
    input  logic       rst,
    input  lnk_ctl_t   ctl,
    input  logic       tick,
    output lnk_state_e state,
    output logic       link_100,
    output logic       txrx_en
);
    lnk_state_e nxt;
    logic       settled;
    logic       run;

    assign run = (state == LNK_SETTLE) && ctl.dv;

    settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick),
        .done (settled)
    );

    always_comb nxt = lnk_next(state, ctl, settled);

    always_ff @(posedge clk) begin
        if (rst) state <= LNK_DOWN;
        else     state <= nxt;
    end

    assign link_100 = (state == LNK_UP) && ctl.dv;
    assign txrx_en  = link_100;

    a_r7_dropout: assert property (@(posedge clk) disable iff (rst)
        !ctl.dv |=> state == LNK_DOWN);
    a_r5_wait_an: assert property (@(posedge clk) disable iff (rst)
        (state == LNK_READY && ctl.dv && ctl.an_en && !ctl.an_ok) |=> state == LNK_READY);
    a_r2_from_down: assert property (@(posedge clk) disable iff (rst)
        state == LNK_DOWN |=> (state == LNK_DOWN || state == LNK_SETTLE));
    a_r3_settle_exit: assert property (@(posedge clk) disable iff (rst)
        (state == LNK_SETTLE && !settled) |=> (state == LNK_SETTLE || state == LNK_DOWN));
    a_r1_reset: assert property (@(posedge clk) rst |=> state == LNK_DOWN);
endmodule

// File: rtl/link_select.sv
module link_select (
    input  logic mode_10,
    input  logic link_10,
    input  logic link_100,
    output logic link_out
);
    always_comb begin
        if (mode_10) link_out = link_10;
        else         link_out = link_100;
    end
endmodule

// File: rtl/link_monitor.sv
module link_monitor
    import link_monitor_pkg::*;
#(
    parameter int SETTLE_TICKS = 330
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       data_valid,
    input  logic       an_enable,
    input  logic       an_link_ok,
    input  logic       mode_10bt,
    input  logic       link_10bt,
    input  logic       ms_tick,
    output logic       link_status,
    output logic       txrx_enable,
    output logic [1:0] fsm_state
);
    lnk_ctl_t   ctl;
    lnk_state_e state;
    logic       link_100;

    assign ctl = '{dv: data_valid, an_en: an_enable, an_ok: an_link_ok};

    link_fsm #(.SETTLE_TICKS(SETTLE_TICKS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .tick     (ms_tick),
        .state    (state),
        .link_100 (link_100),
        .txrx_en  (txrx_enable)
    );

    link_select u_sel (
        .mode_10  (mode_10bt),
        .link_10  (link_10bt),
        .link_100 (link_100),
        .link_out (link_status)
    );

    assign fsm_state = state;

    a_r9_status_match: assert property (@(posedge clk) disable iff (rst)
        !mode_10bt |-> link_status == txrx_enable);
    a_r8_enable_up: assert property (@(posedge clk) disable iff (rst)
        txrx_enable |-> (data_valid && fsm_state == 2'd3));
endmodule

// File: tb/tb_link_monitor.sv
module tb_link_monitor;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_valid = 1'b0, an_enable = 1'b0, an_link_ok = 1'b0;
    logic mode_10bt = 1'b0, link_10bt = 1'b0, ms_tick = 1'b0;
    logic link_status, txrx_enable;
    logic [1:0] fsm_state;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    link_monitor #(.SETTLE_TICKS(N)) dut (
        .clk(clk), .rst(rst), .data_valid(data_valid), .an_enable(an_enable),
        .an_link_ok(an_link_ok), .mode_10bt(mode_10bt), .link_10bt(link_10bt),
        .ms_tick(ms_tick), .link_status(link_status), .txrx_enable(txrx_enable),
        .fsm_state(fsm_state)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic settle(input bit an);
        an_enable = an;
        data_valid = 1'b1;
        step();
        chk("R2 enter settling", fsm_state, 1);
        for (int i = 0; i < N - 1; i++) begin
            ms_tick = 1'b1; step(); ms_tick = 1'b0;
            chk("R3 still settling", fsm_state, 1);
            step();
            chk("R3 no tick no move", fsm_state, 1);
        end
        ms_tick = 1'b1; step(); ms_tick = 1'b0;
        chk(an ? "R5 settle to ready" : "R6 settle to up", fsm_state, an ? 2 : 3);
    endtask

    task automatic drop();
        data_valid = 1'b0; mode_10bt = 1'b0;
        #1;
        chk("R7 link drops same cycle", link_status, 0);
        chk("R7 txrx drops same cycle", txrx_enable, 0);
        step();
        chk("R7 back to down", fsm_state, 0);
    endtask

    initial begin
        @(negedge clk);
        #1;
        chk("R1 reset state", fsm_state, 0);
        chk("R1 reset link", link_status, 0);
        chk("R1 reset txrx", txrx_enable, 0);
        step();
        rst = 1'b0;
        step();
        chk("R1 state after reset", fsm_state, 0);

        ms_tick = 1'b1; step(); ms_tick = 1'b0;
        chk("R3 tick in down ignored", fsm_state, 0);

        for (int an = 0; an < 2; an++) begin
            settle(an[0]);
            for (int m = 0; m < 2; m++) begin
                for (int l = 0; l < 2; l++) begin
                    mode_10bt = m[0]; link_10bt = l[0]; #1;
                    chk("R9 status mux", link_status, m ? l : (an ? 0 : 1));
                    chk("R8 txrx", txrx_enable, an ? 0 : 1);
                end
            end
            mode_10bt = 1'b0;
            if (an != 0) begin
                for (int k = 0; k < 3; k++) begin
                    step();
                    chk("R5 hold ready", fsm_state, 2);
                end
                an_link_ok = 1'b1; step(); an_link_ok = 1'b0;
                chk("R5 an go-ahead to up", fsm_state, 3);
                chk("R9 link up", link_status, 1);
                chk("R8 txrx up", txrx_enable, 1);
            end
            drop();
        end

        settle(1'b1);
        an_enable = 1'b0; step();
        chk("R6 an cleared in ready", fsm_state, 3);
        drop();

        an_enable = 1'b0; data_valid = 1'b1; step();
        for (int i = 0; i < N - 1; i++) begin
            ms_tick = 1'b1; step(); ms_tick = 1'b0;
        end
        data_valid = 1'b0; step();
        chk("R4 dropout in settling", fsm_state, 0);
        data_valid = 1'b1; step();
        chk("R4 resettle", fsm_state, 1);
        for (int i = 0; i < N - 1; i++) begin
            ms_tick = 1'b1; step(); ms_tick = 1'b0;
            chk("R4 count restarted", fsm_state, 1);
        end
        ms_tick = 1'b1; step(); ms_tick = 1'b0;
        chk("R4 full count then up", fsm_state, 3);

        mode_10bt = 1'b1; link_10bt = 1'b0; data_valid = 1'b0; #1;
        chk("R9 10bt low", link_status, 0);
        link_10bt = 1'b1; #1;
        chk("R9 10bt overrides", link_status, 1);
        chk("R7 txrx off without valid", txrx_enable, 0);
        step();
        chk("R7 down", fsm_state, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule